// File: doc/BRIEF.md
# VID transition controller

This block watches the voltage-identification code that a processor presents to its core regulator and decides when the processor has really asked for a new voltage. A new value becomes valid only after it has been sampled unchanged for a programmable number of clock edges. Shorter excursions are treated as glitches and dropped. Once a new value is accepted, the block latches it and starts a long one-shot, the slew window. The regulator needs this window to move its output to the new level.

For the whole slew window the block changes several modes together:
- It masks the output over- and under-voltage protections.
- It raises a flag that can gate an external switch to lower the current-limit threshold.
- It turns off zero-cross detection, so inductor current may reverse.
- It turns on negative current limiting.

If another qualified change arrives inside the window, the window restarts from full length. All timing is in clock cycles. At 50 MHz the defaults give a 200 ns filter (10 cycles) and a 100 µs window (5000 cycles). The input code is assumed to be synchronous to `clk`.

The controller is a three-state machine:
- `VT_BOOT` is the first cycle after reset. It adopts the present code as baseline and never flags a transition for it.
- `VT_QUIET` is normal regulation.
- `VT_SLEW` is the slew window.

Its transitions are:
- BOOT→QUIET: always after one cycle.
- QUIET→SLEW: on a qualified change.
- SLEW→SLEW: on a qualified change, which restarts the timer.
- SLEW→QUIET: when the timer expires with no new qualified change in the same cycle.

Top module: `vidt_ctrl`

## Requirements
- R1: While `rst_n` is low, `vid_code_o` is 0, `trans_flag_o` and `neg_ilim_en_o` are 0, and `prot_en_o` and `zc_en_o` are 1.
- R2: At the first rising edge after reset is released, `vid_code_o` takes the value of `vid_in`, and no transition is flagged for it.
- R3: A value different from `vid_code_o` that is sampled on fewer than FILT_CYC consecutive edges leaves `vid_code_o` and all mode outputs unchanged.
- R4: A value different from `vid_code_o` that is sampled on FILT_CYC consecutive edges is copied to `vid_code_o` at the FILT_CYC-th of those edges.
- R5: `trans_flag_o` goes high at the edge where a change is qualified and stays high for exactly HOLD_CYC cycles.
- R6: `prot_en_o` is the complement of `trans_flag_o`: protections are masked exactly during the slew window.
- R7: `zc_en_o` is the complement of `trans_flag_o`: zero-cross detection is off exactly during the slew window.
- R8: `neg_ilim_en_o` equals `trans_flag_o`: negative current limiting is on exactly during the slew window.
- R9: A change qualified while the window is open, including at the very edge where it would expire, reloads the window to a full HOLD_CYC cycles counted from that edge.
- R10: If the candidate value switches to another value that differs from `vid_code_o`, the count starts again from one for the new value.
- R11: If `vid_in` returns to `vid_code_o` before qualification, the pending candidate is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_in | input | VID_W | Voltage-identification code from the processor |
| vid_code_o | output | VID_W | Latched code, updated only on qualified changes |
| trans_flag_o | output | 1 | High during the slew window; drives the current-limit reduction switch |
| prot_en_o | output | 1 | Output over/under-voltage protections enabled |
| zc_en_o | output | 1 | Zero-cross detection enabled |
| neg_ilim_en_o | output | 1 | Negative current limiting enabled |

## Verification
Window expiry and a fresh qualification can land on the same edge. The fresh qualification must win: the flag must not drop for a cycle, and the timer must reload in full. The bench provokes this directly by starting a second value exactly HOLD_CYC−FILT_CYC cycles after the first one is accepted. Random segment lengths near the filter length also produce it by chance. Every cycle the outputs are judged against a bench model of the requirements, which must show the flag continuously high and lasting HOLD_CYC cycles from the later qualification.

// File: rtl/vidt_pkg.sv
package vidt_pkg;

    typedef enum logic [1:0] {
        VT_BOOT  = 2'd0,
        VT_QUIET = 2'd1,
        VT_SLEW  = 2'd2
    } vidt_state_e;

endpackage

// File: rtl/vidt_deglitch.sv
// Qualifies a new code once it has been sampled FILT_CYC times in a row.
module vidt_deglitch #(
    parameter int VID_W    = 5,
    parameter int FILT_CYC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [VID_W-1:0] vid_in,
    input  logic [VID_W-1:0] base,
    output logic             qual
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic             armed_q;
    logic [VID_W-1:0] cand_q;
    logic [CW-1:0]    cnt_q;
    logic             differs;
    logic             same_cand;

    always_comb begin
        differs   = (vid_in != base);
        same_cand = armed_q && (vid_in == cand_q);
        qual      = enable && differs &&
                    ((FILT_CYC == 1) || (same_cand && (cnt_q == LAST)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cand_q  <= '0;
            cnt_q   <= '0;
        end else if (!enable || !differs || qual) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!same_cand) begin
            armed_q <= 1'b1;
            cand_q  <= vid_in;
            cnt_q   <= CW'(1);
        end else begin
            cnt_q   <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/vidt_holdtimer.sv
// Reloadable one-shot: busy for HOLD_CYC cycles after each start.
module vidt_holdtimer #(
    parameter int HOLD_CYC = 5000,
    parameter int TW       = $clog2(HOLD_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [TW-1:0] cnt_o,
    output logic          expire
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= TW'(HOLD_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign cnt_o  = cnt_q;
    assign expire = (cnt_q == TW'(1));

endmodule

// File: rtl/vidt_ctrl.sv
module vidt_ctrl #(
    parameter int VID_W    = 5,
    parameter int FILT_CYC = 10,
    parameter int HOLD_CYC = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VID_W-1:0] vid_in,
    output logic [VID_W-1:0] vid_code_o,
    output logic             trans_flag_o,
    output logic             prot_en_o,
    output logic             zc_en_o,
    output logic             neg_ilim_en_o
);
    import vidt_pkg::*;

    localparam int TW = $clog2(HOLD_CYC + 1);

    vidt_state_e      state_q;
    vidt_state_e      state_d;
    logic [VID_W-1:0] code_q;
    logic             qual;
    logic             expire;
    logic [TW-1:0]    tmr_cnt;
    logic             filt_en;

    assign filt_en = (state_q != VT_BOOT);

    vidt_deglitch #(
        .VID_W    (VID_W),
        .FILT_CYC (FILT_CYC)
    ) u_deglitch (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (filt_en),
        .vid_in (vid_in),
        .base   (code_q),
        .qual   (qual)
    );

    vidt_holdtimer #(
        .HOLD_CYC (HOLD_CYC),
        .TW       (TW)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (qual),
        .cnt_o  (tmr_cnt),
        .expire (expire)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VT_BOOT:  state_d = VT_QUIET;
            VT_QUIET: if (qual) state_d = VT_SLEW;
            VT_SLEW:  if (!qual && expire) state_d = VT_QUIET;
            default:  state_d = VT_BOOT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VT_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // latched code: baseline in BOOT, then only qualified values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (state_q == VT_BOOT || qual) begin
            code_q <= vid_in;
        end
    end

    // outputs
    always_comb begin
        vid_code_o    = code_q;
        trans_flag_o  = 1'b0;
        prot_en_o     = 1'b1;
        zc_en_o       = 1'b1;
        neg_ilim_en_o = 1'b0;
        unique case (state_q)
            VT_BOOT, VT_QUIET: ;
            VT_SLEW: begin
                trans_flag_o  = 1'b1;
                prot_en_o     = 1'b0;
                zc_en_o       = 1'b0;
                neg_ilim_en_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vidt_ctrl_chk.sv
module vidt_ctrl_chk #(
    parameter int VID_W    = 5,
    parameter int HOLD_CYC = 5000,
    parameter int TW       = $clog2(HOLD_CYC + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [VID_W-1:0]      vid_in,
    input logic [VID_W-1:0]      vid_code_o,
    input logic                  trans_flag_o,
    input logic                  prot_en_o,
    input logic                  zc_en_o,
    input logic                  neg_ilim_en_o,
    input logic                  qual,
    input logic [TW-1:0]         tmr_cnt,
    input vidt_pkg::vidt_state_e state_q
);
    import vidt_pkg::*;

    // R4: after boot the code only moves when a window opens or restarts
    a_r4_code_moves_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(vid_code_o) && ($past(state_q) != VT_BOOT)) |-> trans_flag_o);

    // R3: qualification requires a value that differs from the latched code
    a_r3_qual_needs_diff: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> (vid_in != vid_code_o));

    // R5: the window opens with a full timer load
    a_r5_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trans_flag_o) |-> (tmr_cnt == TW'(HOLD_CYC)));

    // R5: the flag lasts exactly as long as the timer is running
    a_r5_flag_tracks_timer: assert property (@(posedge clk) disable iff (!rst_n)
        trans_flag_o == (tmr_cnt != '0));

    // R9: requalifying inside the window reloads the timer
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && (state_q == VT_SLEW)) |=> (trans_flag_o && tmr_cnt == TW'(HOLD_CYC)));

    // R6 R7 R8: modes switch together with the flag
    a_r6_modes_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        trans_flag_o |-> (!prot_en_o && !zc_en_o && neg_ilim_en_o));

    a_r8_modes_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !trans_flag_o |-> (prot_en_o && zc_en_o && !neg_ilim_en_o));

endmodule

bind vidt_ctrl vidt_ctrl_chk #(
    .VID_W    (VID_W),
    .HOLD_CYC (HOLD_CYC),
    .TW       (TW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vid_in        (vid_in),
    .vid_code_o    (vid_code_o),
    .trans_flag_o  (trans_flag_o),
    .prot_en_o     (prot_en_o),
    .zc_en_o       (zc_en_o),
    .neg_ilim_en_o (neg_ilim_en_o),
    .qual          (qual),
    .tmr_cnt       (tmr_cnt),
    .state_q       (state_q)
);

// File: tb/test_vidt_ctrl.sv
`timescale 1ns/1ps
module test_vidt_ctrl;
    localparam int VW   = 5;
    localparam int FILT = 6;
    localparam int HOLD = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] vid = '0;
    logic [VW-1:0] code_o;
    logic          flag_o, prot_o, zc_o, neg_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // bench model state
    bit            m_boot = 1'b1;
    logic [VW-1:0] m_code = '0;
    logic [VW-1:0] m_last = '0;
    int            m_run  = 0;
    int            m_tmr  = 0;

    always #2 clk = ~clk;

    vidt_ctrl #(.VID_W(VW), .FILT_CYC(FILT), .HOLD_CYC(HOLD)) i_vidt_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .vid_in        (vid),
        .vid_code_o    (code_o),
        .trans_flag_o  (flag_o),
        .prot_en_o     (prot_o),
        .zc_en_o       (zc_o),
        .neg_ilim_en_o (neg_o)
    );

    function automatic int next_run(logic [VW-1:0] v, logic [VW-1:0] code,
                                    logic [VW-1:0] last, int run);
        if (v == code) return 0;
        if (run > 0 && v == last) return run + 1;
        return 1;
    endfunction

    function automatic bit exp_flag(int tmr);
        return tmr > 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_boot = 1'b1; m_code = '0; m_last = '0; m_run = 0; m_tmr = 0;
        end else if (m_boot) begin
            m_boot = 1'b0; m_code = vid; m_last = vid; m_run = 0;
        end else begin
            m_run  = next_run(vid, m_code, m_last, m_run);
            m_last = vid;
            if (m_run >= FILT) begin
                m_code = vid; m_run = 0; m_tmr = HOLD;
            end else if (m_tmr > 0) begin
                m_tmr = m_tmr - 1;
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit f;
        f = exp_flag(m_tmr);
        chk("R2 R3 R4 R10 R11 code", 32'(code_o), 32'(m_code));
        chk("R5 R9 flag", 32'(flag_o), 32'(f));
        chk("R6 prot_en", 32'(prot_o), 32'(!f));
        chk("R7 zc_en", 32'(zc_o), 32'(!f));
        chk("R8 neg_ilim", 32'(neg_o), 32'(f));
    endtask

    // one cycle: check at negedge, then drive the next input
    task automatic cyc(logic [VW-1:0] v);
        @(negedge clk);
        compare();
        vid = v;
    endtask

    task automatic hold(logic [VW-1:0] v, int n);
        for (int i = 0; i < n; i++) cyc(v);
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        void'($urandom(32'h5EED_0C0D));
        vid = 5'h0A;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 code", 32'(code_o), 32'h0);
        chk("R1 flag", 32'(flag_o), 32'h0);
        chk("R1 prot_en", 32'(prot_o), 32'h1);
        chk("R1 zc_en", 32'(zc_o), 32'h1);
        chk("R1 neg_ilim", 32'(neg_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 baseline adopted without a window
        chk("R2 baseline", 32'(code_o), 32'h0A);
        chk("R2 no flag", 32'(flag_o), 32'h0);
        hold(5'h0A, 4);
        // R3 glitch one sample short
        hold(5'h13, FILT - 1);
        hold(5'h0A, 10);
        chk("R3 glitch ignored", 32'(code_o), 32'h0A);
        // R4 R5 full qualification
        hold(5'h13, FILT);
        hold(5'h13, 1);
        chk("R4 code taken", 32'(code_o), 32'h13);
        chk("R5 flag up", 32'(flag_o), 32'h1);
        hold(5'h13, 20);
        // R9 restart mid window
        hold(5'h07, FILT + 10);
        hold(5'h07, HOLD + 5);
        // R9 qualification on the expiry edge
        hold(5'h11, FILT);
        hold(5'h11, HOLD - FILT);
        hold(5'h15, FILT);
        hold(5'h15, 1);
        chk("R9 expiry collision flag", 32'(flag_o), 32'h1);
        hold(5'h15, HOLD + 5);
        // R10 candidate switches
        hold(5'h01, FILT - 2);
        hold(5'h02, FILT - 1);
        hold(5'h02, 1);
        chk("R10 needs own count", 32'(code_o), 32'h15);
        hold(5'h02, HOLD + 5);
        // R11 return to code discards candidate
        hold(5'h1F, FILT - 2);
        hold(5'h02, 1);
        hold(5'h1F, FILT - 2);
        hold(5'h02, 1);
        chk("R11 discarded", 32'(code_o), 32'h02);
        chk("R11 no flag", 32'(flag_o), 32'h0);
        hold(5'h02, 5);
        // random segments
        for (int s = 0; s < 500; s++) begin
            logic [VW-1:0] v;
            int n;
            v = ($urandom % 4 == 0) ? m_code : VW'($urandom);
            n = ($urandom % 8 == 0) ? 1 + int'($urandom % (HOLD + 10))
                                    : 1 + int'($urandom % (FILT + 3));
            hold(v, n);
        end
        hold(vid, HOLD + 5);
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R5 watchdog: actual=running expected=finished");
            report();
            $finish;
        end
    end

endmodule